// File: doc/BRIEF.md
# Command-Mode Serial Register Port

This block is the serial slave that gives a host access to a converter's control registers over a three-wire synchronous link with an active-low chip select. Each access starts with an 8-bit command byte. The byte picks one 24-bit register and a direction. The next 24 serial clocks either write that register from the data input or read it out on the data output, most significant bit first. When the data phase ends, the port is back in command mode. The following 8 bits in the same frame are then taken as a fresh command.

The serial clock, chip select and data input are brought into the system clock domain through flop synchronisers, and serial clock edges are detected there. Because of this the serial clock may run continuously, with the chip select alone framing transfers. The registers live in a small internal file: one configuration word, plus one offset word and one gain word per channel. The data output is described as a value and an output enable, and a pad outside the block makes the tri-state.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset the port is in command mode, `sdo_oe` and `sdo` are 0, and the registers hold configuration 0, every offset 0, and every gain `0x400000`.
- R2: With `cs_n` low, the first 8 bits sampled on rising `sclk` edges form the command byte, most significant bit first, and `sdo` stays 0 while a command is shifted in.
- R3: Command byte fields: bit 7 must be 0, bit 6 is 1 for read and 0 for write, bits 5:4 pick the kind (00 offset, 01 gain, 10 configuration, 11 invalid), bit 3 must be 0, and bits 2:0 give the channel. The channel must be below `NUM_CH`, and it must be 0 for configuration.
- R4: A command byte that breaks any rule of R3 is dropped without touching any register, and the next 8 bits are taken as a new command.
- R5: A write command takes 24 further bits from `sdi` on rising `sclk` edges, most significant bit first. The target register changes only after the 24th bit.
- R6: A read command fetches the target register when the command byte completes. Its bit 23 appears on `sdo` after the next falling `sclk` edge, and each later falling edge presents the next lower bit, ready for the host to sample on the rising edge.
- R7: After the 24-bit data phase the port is in command mode again inside the same frame, so transfers can run back to back.
- R8: Raising `cs_n` before a command or data phase completes abandons it: no register changes, and the next frame starts in command mode.
- R9: `sdo_oe` follows the synchronised chip select (1 while selected, 0 while released, three clocks after the pin), and `sdo` is 0 whenever it is not carrying read data.
- R10: `sclk` edges while `cs_n` is high have no effect on the registers or the port state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to `clk` |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |

## Verification
On every cycle, the checker confirms that the output enable tracks the synchronised chip select and that `sdo` is quiet when it is not enabled. It also checks that `sdo` only moves after a detected falling serial clock edge, and that register writes and fetches happen only right after a rising edge taken while selected. Only the bench's scenarios can show that command fields are decoded correctly, that written values come back bit for bit, and that aborted, invalid or idle-clock traffic leaves the registers unchanged. It does this by writing through the serial port and reading back through the same port.

// File: rtl/csp_pkg.sv
package csp_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    KIND_OFFSET = 2'b00,
    KIND_GAIN   = 2'b01,
    KIND_CONFIG = 2'b10,
    KIND_NONE   = 2'b11
  } reg_kind_e;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } port_state_e;

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES < 2) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= RST_VAL;
        else     stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/csp_edge.sv
module csp_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

endmodule

// File: rtl/csp_cmd_decode.sv
module csp_cmd_decode
  import csp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic [CMD_W-1:0]  cmd_byte,
  output logic              cmd_valid,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr
);

  reg_kind_e  kind;
  logic [2:0] chan;
  logic       chan_ok;
  logic       frame_ok;

  assign kind     = reg_kind_e'(cmd_byte[5:4]);
  assign chan     = cmd_byte[2:0];
  assign chan_ok  = int'(chan) < NUM_CH;
  assign frame_ok = ~cmd_byte[7] & ~cmd_byte[3];
  assign cmd_read = cmd_byte[6];

  always_comb begin
    cmd_valid = 1'b0;
    cmd_addr  = '0;
    unique case (kind)
      KIND_CONFIG: begin
        cmd_valid = frame_ok & (chan == 3'd0);
        cmd_addr  = '0;
      end
      KIND_OFFSET: begin
        cmd_valid = frame_ok & chan_ok;
        cmd_addr  = ADDR_W'(int'(chan) + 1);
      end
      KIND_GAIN: begin
        cmd_valid = frame_ok & chan_ok;
        cmd_addr  = ADDR_W'(int'(chan) + 1 + NUM_CH);
      end
      default: begin
        cmd_valid = 1'b0;
        cmd_addr  = '0;
      end
    endcase
  end

endmodule

// File: rtl/csp_regfile.sv
module csp_regfile #(
  parameter int                NUM_CH   = 4,
  parameter int                WORD_W   = 24,
  parameter int                ADDR_W   = 4,
  parameter logic [WORD_W-1:0] GAIN_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 + 2 * NUM_CH;

  logic [WORD_W-1:0] mem_q [DEPTH];

  function automatic logic [WORD_W-1:0] reset_word(input int idx);
    return (idx > NUM_CH) ? GAIN_RST : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= reset_word(i);
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;
  end

endmodule

// File: rtl/csp_port_ctrl.sv
module csp_port_ctrl
  import csp_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  output logic [CMD_W-1:0]  cmd_byte,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic              reg_re,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  port_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              load_q;
  logic [WORD_W-1:0] shifted_in;

  assign shifted_in = {sh_q[WORD_W-2:0], sdi_s};
  assign cmd_byte   = shifted_in[CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMD;
      cnt_q     <= '0;
      sh_q      <= '0;
      load_q    <= 1'b0;
      reg_addr  <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_wdata <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      load_q <= reg_re;
      sdo_oe <= cs_act;
      if (load_q) sh_q <= rdata;
      if (!cs_act) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
        sdo     <= 1'b0;
      end else if (sclk_rise) begin
        unique case (state_q)
          ST_CMD: begin
            sh_q <= shifted_in;
            if (cnt_q == CMD_LAST) begin
              cnt_q <= '0;
              if (cmd_valid) begin
                reg_addr <= cmd_addr;
                reg_re   <= cmd_read;
                state_q  <= cmd_read ? ST_RD : ST_WR;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WR: begin
            sh_q <= shifted_in;
            if (cnt_q == WORD_LAST) begin
              reg_we    <= 1'b1;
              reg_wdata <= shifted_in;
              state_q   <= ST_CMD;
              cnt_q     <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD: begin
            if (cnt_q == WORD_LAST) begin
              state_q <= ST_CMD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
        endcase
      end else if (sclk_fall) begin
        if (state_q == ST_RD) begin
          sdo  <= sh_q[WORD_W-1];
          sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end else begin
          sdo <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port
  import csp_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  localparam int                DEPTH    = 1 + 2 * NUM_CH;
  localparam int                ADDR_W   = $clog2(DEPTH);
  localparam logic [WORD_W-1:0] GAIN_RST = {2'b01, {(WORD_W-2){1'b0}}};

  logic              cs_n_s;
  logic              cs_act;
  logic              sclk_s;
  logic              sdi_s;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [CMD_W-1:0]  cmd_byte;
  logic              cmd_valid;
  logic              cmd_read;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_we;
  logic              reg_re;
  logic [WORD_W-1:0] reg_wdata;
  logic [WORD_W-1:0] reg_rdata;

  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_n_s)
  );
  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s)
  );
  csp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .d(sdi), .q(sdi_s)
  );

  assign cs_act = ~cs_n_s;

  csp_edge u_sclk_edge (
    .clk(clk), .rst(rst), .level(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
  );

  csp_cmd_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr)
  );

  csp_port_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_act(cs_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
    .rdata(reg_rdata), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  csp_regfile #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .GAIN_RST(GAIN_RST)) u_regs (
    .clk(clk), .rst(rst),
    .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .re(reg_re), .raddr(reg_addr), .rdata(reg_rdata)
  );

endmodule

// File: rtl/cmd_serial_port_chk.sv
module cmd_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic reg_we,
  input logic reg_re,
  input logic sdo,
  input logic sdo_oe
);

  a_r9_oe_on: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> sdo_oe);

  a_r9_oe_off: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_oe);

  a_r9_quiet_released: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

  a_r5_write_after_rise: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> ($past(sclk_rise) && $past(cs_act)));

  a_r6_fetch_after_rise: assert property (@(posedge clk) disable iff (rst)
    reg_re |-> ($past(sclk_rise) && $past(cs_act)));

  a_r6_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act) && !$stable(sdo)) |-> $past(sclk_fall));

  a_r4_single_access: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, reg_re}));

endmodule

bind cmd_serial_port cmd_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .reg_we(reg_we), .reg_re(reg_re), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/cmd_serial_port_bench.sv
`timescale 1ns/1ps
module cmd_serial_port_bench;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic sdo_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit chk_on = 0;

  logic [23:0] model_q [9];
  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;

  always #2.5 clk = ~clk;

  cmd_serial_port u_cmd_serial_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin history for the per-clock enable model (R9)
  always @(posedge clk) begin
    h3 <= h2;
    h2 <= h1;
    h1 <= cs_n;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R9 sdo_oe tracks chip select", {31'b0, sdo_oe}, {31'b0, ~h3});
      if (h3) check("R9 sdo low while released", {31'b0, sdo}, 32'd0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mkcmd(input bit rd, input int kind, input int ch);
    return {1'b0, rd, 2'(kind), 1'b0, 3'(ch)};
  endfunction

  function automatic void bdec(input logic [7:0] c, output bit v, output bit rd, output int idx);
    int ch;
    int k;
    ch  = int'(c[2:0]);
    k   = int'(c[5:4]);
    rd  = c[6];
    v   = !c[7] && !c[3];
    idx = 0;
    if (k == 2) v = v && (ch == 0);
    else if (k == 0) begin v = v && (ch < 4); idx = 1 + ch; end
    else if (k == 1) begin v = v && (ch < 4); idx = 5 + ch; end
    else v = 0;
  endfunction

  task automatic bit_io(input logic din, output logic seen);
    sdi = din;
    tick(HALF);
    seen = sdo;
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame_begin();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  // Command byte plus nbits of data phase; the model only changes on a full valid write
  task automatic xfer(input string tag, input logic [7:0] cmd, input logic [23:0] wdata, input int nbits);
    logic seen;
    bit v;
    bit rd;
    int idx;
    bdec(cmd, v, rd, idx);
    for (int i = 0; i < 8; i++) begin
      bit_io(cmd[7-i], seen);
      check("R2 sdo quiet during command byte", {31'b0, seen}, 32'd0);
    end
    for (int i = 0; i < nbits; i++) begin
      bit_io(rd ? 1'($urandom % 2) : wdata[23-i], seen);
      if (v && rd) check(tag, {31'b0, seen}, {31'b0, model_q[idx][23-i]});
      else         check("R9 sdo quiet in write phase", {31'b0, seen}, 32'd0);
    end
    if (v && !rd && nbits == 24) model_q[idx] = wdata;
  endtask

  task automatic read_all(input string tag);
    frame_begin();
    xfer(tag, mkcmd(1, 2, 0), 24'h0, 24);
    for (int c = 0; c < 4; c++) xfer(tag, mkcmd(1, 0, c), 24'h0, 24);
    for (int c = 0; c < 4; c++) xfer(tag, mkcmd(1, 1, c), 24'h0, 24);
    frame_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) model_q[i] = (i >= 5) ? 24'h400000 : 24'h0;
    tick(4);
    check("R1 sdo_oe low in reset", {31'b0, sdo_oe}, 32'd0);
    check("R1 sdo low in reset", {31'b0, sdo}, 32'd0);
    rst = 1'b0;
    tick(4);
    chk_on = 1;

    // R1: reset values read back through the port
    read_all("R1 reset value read");

    // R3/R5/R6: writes to each register kind, then read back
    frame_begin();
    xfer("R5 write", mkcmd(0, 2, 0), 24'hA5C3E1, 24);
    frame_end();
    frame_begin();
    xfer("R5 write", mkcmd(0, 0, 2), 24'h800001, 24);
    frame_end();
    frame_begin();
    xfer("R5 write", mkcmd(0, 1, 3), 24'h123456, 24);
    frame_end();
    read_all("R3 kind and channel addressing");

    // R7: back-to-back transfers in one frame
    frame_begin();
    xfer("R7 back to back", mkcmd(0, 0, 0), 24'h7FFFFE, 24);
    xfer("R7 back to back read", mkcmd(1, 0, 0), 24'h0, 24);
    xfer("R7 back to back", mkcmd(0, 1, 1), 24'hFFFFFF, 24);
    xfer("R7 back to back read", mkcmd(1, 1, 1), 24'h0, 24);
    frame_end();

    // R4: invalid command bytes dropped, next byte decoded
    frame_begin();
    xfer("R4", 8'h85, 24'h0, 0);            // bit 7 set
    xfer("R4", mkcmd(0, 3, 0), 24'h0, 0);   // kind 11
    xfer("R4", mkcmd(0, 2, 1), 24'h0, 0);   // config with channel 1
    xfer("R4", mkcmd(0, 0, 5), 24'h0, 0);   // channel out of range
    xfer("R4", 8'h0A, 24'h0, 0);            // bit 3 set
    xfer("R4 read after dropped bytes", mkcmd(1, 0, 1), 24'h0, 24);
    frame_end();
    read_all("R4 registers untouched");

    // R8: aborts in data phase and in command byte
    frame_begin();
    xfer("R8 partial write", mkcmd(0, 0, 2), 24'h0F0F0F, 10);
    frame_end();
    frame_begin();
    for (int i = 0; i < 4; i++) begin
      logic seen;
      bit_io(1'b0, seen);
      check("R8 sdo quiet in partial command", {31'b0, seen}, 32'd0);
    end
    frame_end();
    frame_begin();
    xfer("R8 write 23 bits", mkcmd(0, 1, 0), 24'hDEAD00, 23);
    frame_end();
    read_all("R8 abort leaves registers");

    // R10: serial clock running with chip select high
    for (int i = 0; i < 40; i++) begin
      sdi = 1'($urandom % 2);
      tick(HALF);
      sclk = ~sclk;
    end
    sclk = 1'b0;
    tick(HALF);
    read_all("R10 idle clocks ignored");

    // R6: read the same register twice across frames, alternating pattern
    frame_begin();
    xfer("R6 write pattern", mkcmd(0, 0, 3), 24'h555AAA, 24);
    frame_end();
    frame_begin();
    xfer("R6 read data bits", mkcmd(1, 0, 3), 24'h0, 24);
    frame_end();

    tick(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule